// File: doc/BRIEF.md
# Address-Routed Bus Splitter with Priority Arbitration

This block sits between three bus requesters and four 32-bit downstream ports. The requesters are core data (index 0), core instruction fetch (index 1) and debug (index 2). The ports are an instruction code port (index 0), a data/debug code port (index 1), a system port (index 2) and a private peripheral port (index 3). Each request is decoded from its address, its requester type, its size and its privilege, and is then steered to exactly one port. Some requests are refused instead, and a refused request is answered with an error at once, without reaching any port.

When several requesters want the same port in the same cycle, a fixed-priority arbiter picks one of them. The lower requester index wins, so data beats fetch and fetch beats debug. The requesters that lose see their ready held low until their own turn comes. Once a requester holds a port, it keeps that port until the port signals completion, so a higher-priority request arriving later waits. The completion handshake, the read data and the error flag from the port are passed back only to the requester that owns that port.

A requester holds `valid` and its request fields steady until it sees `ready`. A port holds its request until it raises `ready`, and that transfer completes in the cycle where `valid` and `ready` are both high.

Top module: `bus_route_top`

## Requirements
- R1: A fetch (requester 1) to 0x00000000–0x1FFFFFFF goes to port 0. A debug request (requester 2) is never granted port 0.
- R2: Data or debug requests to 0x00000000–0x1FFFFFFF go to port 1.
- R3: Requests from any requester to 0x20000000–0xDFFFFFFF or 0xE0100000–0xFFFFFFFF go to port 2.
- R4: Data or debug requests to 0xE0040000–0xE00FFFFF go to port 3. On port 3, every address bit at position PPB_AW and above is driven to zero.
- R5: A request to the 0xE0040000–0xE00FFFFF window is refused in three cases: it is a fetch, it is unprivileged (`priv`=0), or its size code is not 2. Size codes are 0 for 8-bit, 1 for 16-bit and 2 for 32-bit. A refused request gets `ready`=1 and `err`=1 in the cycle it is presented, with read data 0, and no port sees it.
- R6: Any request to 0xE0000000–0xE003FFFF gets `ready`=1 and `err`=1 in the cycle it is presented, with read data 0. No port is driven for it.
- R7: Simultaneous requests for port 2 are served in the order data, then fetch, then debug. On ports 1 and 3, data is served before debug.
- R8: A granted requester keeps its port, with address and control held stable, until that port raises `ready`. A request that arrives later is not served first, whatever its priority.
- R9: A requester's `ready`, `err` and `rdata` come from the port it owns, in the cycle that port raises `ready`. Port read data is returned unchanged, and an error from the port is passed through.
- R10: A requester that is waiting for a port held by, or granted to, another requester sees `ready`=0.
- R11: While reset is held and just after it is released, with no requests present, no port is valid and no requester sees `ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rq_valid | input | 3 | Request valid per requester (0 data, 1 fetch, 2 debug) |
| rq_addr | input | 3x32 | Request address per requester |
| rq_write | input | 3 | Write flag per requester |
| rq_size | input | 3x2 | Size code per requester (0 byte, 1 half, 2 word) |
| rq_priv | input | 3 | Privileged access flag per requester |
| rq_wdata | input | 3xDATA_W | Write data per requester |
| rq_ready | output | 3 | Request completes this cycle |
| rq_err | output | 3 | Error response, valid with rq_ready |
| rq_rdata | output | 3xDATA_W | Read data, valid with rq_ready |
| dp_valid | output | 4 | Port request valid (0 icode, 1 dcode, 2 system, 3 peripheral) |
| dp_addr | output | 4x32 | Port address (port 3 truncated to PPB_AW bits) |
| dp_write | output | 4 | Port write flag |
| dp_size | output | 4x2 | Port size code |
| dp_wdata | output | 4xDATA_W | Port write data |
| dp_ready | input | 4 | Port completes the current transfer |
| dp_err | input | 4 | Port error response |
| dp_rdata | input | 4xDATA_W | Port read data |

## Verification
The bench builds the block with its default parameters: a 32-bit data path and PPB_AW of 20. With PPB_AW at 20, a peripheral address shows up on port 3 with its top twelve bits cleared, so the returned data proves the truncation. The bench sets a separate wait count for each port model. With zero waits it checks single-cycle routing. With several waits it holds a port long enough that later, higher-priority requests pile up behind the owner, which lets it measure both the lock and the priority order from the completion cycles.

// File: rtl/xbar_route_pkg.sv
package xbar_route_pkg;
  localparam int NREQ   = 3;
  localparam int NPORT  = 4;
  localparam int ADDR_W = 32;

  // requester indices, lower index = higher priority
  localparam int RQ_DATA  = 0;
  localparam int RQ_FETCH = 1;
  localparam int RQ_DEBUG = 2;

  typedef enum logic [1:0] {
    PT_ICODE = 2'd0,
    PT_DCODE = 2'd1,
    PT_SYS   = 2'd2,
    PT_PPB   = 2'd3
  } port_e;

  typedef struct packed {
    logic  hit;
    logic  fault;
    port_e port;
  } route_t;
endpackage

// File: rtl/route_decode.sv
module route_decode
  import xbar_route_pkg::*;
#(
  parameter bit IS_FETCH = 1'b0
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              priv,
  output route_t            route
);
  logic code_win, pp_region, ppb_win, int_win;

  always_comb begin
    code_win  = (addr[31:29] == 3'b000);
    pp_region = (addr[31:20] == 12'hE00);
    ppb_win   = pp_region && (addr[19:18] != 2'b00);
    int_win   = pp_region && (addr[19:18] == 2'b00);

    route       = '0;
    route.port  = PT_SYS;
    if (valid) begin
      if (code_win) begin
        route.hit  = 1'b1;
        route.port = IS_FETCH ? PT_ICODE : PT_DCODE;
      end else if (ppb_win) begin
        if (!IS_FETCH && priv && (size == 2'd2)) begin
          route.hit  = 1'b1;
          route.port = PT_PPB;
        end else begin
          route.fault = 1'b1;
        end
      end else if (int_win) begin
        route.fault = 1'b1;
      end else begin
        route.hit  = 1'b1;
        route.port = PT_SYS;
      end
    end
  end
endmodule

// File: rtl/port_arbiter.sv
module port_arbiter #(
  parameter int NR = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NR-1:0] req,
  input  logic          done,
  output logic [NR-1:0] gnt
);
  logic          lock_q, lock_d;
  logic [NR-1:0] own_q, own_d;
  logic [NR-1:0] pick;
  logic          found;
  logic          upd_en;

  // fixed priority: lowest index wins
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NR; i++) begin
      if (req[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    gnt    = lock_q ? own_q : pick;
    lock_d = (|gnt) && !done;
    own_d  = gnt;
    upd_en = (|gnt) || lock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      own_q  <= '0;
    end else if (upd_en) begin
      lock_q <= lock_d;
      own_q  <= own_d;
    end
  end
endmodule

// File: rtl/bus_route_top.sv
module bus_route_top
  import xbar_route_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PPB_AW = 20
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NREQ-1:0]                     rq_valid,
  input  logic [NREQ-1:0][ADDR_W-1:0]         rq_addr,
  input  logic [NREQ-1:0]                     rq_write,
  input  logic [NREQ-1:0][1:0]                rq_size,
  input  logic [NREQ-1:0]                     rq_priv,
  input  logic [NREQ-1:0][DATA_W-1:0]         rq_wdata,
  output logic [NREQ-1:0]                     rq_ready,
  output logic [NREQ-1:0]                     rq_err,
  output logic [NREQ-1:0][DATA_W-1:0]         rq_rdata,
  output logic [NPORT-1:0]                    dp_valid,
  output logic [NPORT-1:0][ADDR_W-1:0]        dp_addr,
  output logic [NPORT-1:0]                    dp_write,
  output logic [NPORT-1:0][1:0]               dp_size,
  output logic [NPORT-1:0][DATA_W-1:0]        dp_wdata,
  input  logic [NPORT-1:0]                    dp_ready,
  input  logic [NPORT-1:0]                    dp_err,
  input  logic [NPORT-1:0][DATA_W-1:0]        dp_rdata
);
  localparam logic [ADDR_W-1:0] PPB_MASK = ADDR_W'((64'd1 << PPB_AW) - 64'd1);

  route_t                           rt [NREQ];
  logic [NPORT-1:0][NREQ-1:0]       port_req;
  logic [NPORT-1:0][NREQ-1:0]       port_gnt;

  for (genvar r = 0; r < NREQ; r++) begin : g_dec
    route_decode #(.IS_FETCH(r == RQ_FETCH)) u_dec (
      .valid (rq_valid[r]),
      .addr  (rq_addr[r]),
      .size  (rq_size[r]),
      .priv  (rq_priv[r]),
      .route (rt[r])
    );
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    for (genvar r = 0; r < NREQ; r++) begin : g_req
      assign port_req[p][r] = rt[r].hit && (rt[r].port == port_e'(p));
    end
    port_arbiter #(.NR(NREQ)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (port_req[p]),
      .done  (dp_ready[p]),
      .gnt   (port_gnt[p])
    );
  end

  // port-side request mux
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      dp_valid[p] = |port_gnt[p];
      dp_addr[p]  = '0;
      dp_write[p] = 1'b0;
      dp_size[p]  = '0;
      dp_wdata[p] = '0;
      for (int r = 0; r < NREQ; r++) begin
        if (port_gnt[p][r]) begin
          dp_addr[p]  = dp_addr[p]  | rq_addr[r];
          dp_write[p] = dp_write[p] | rq_write[r];
          dp_size[p]  = dp_size[p]  | rq_size[r];
          dp_wdata[p] = dp_wdata[p] | rq_wdata[r];
        end
      end
      if (p == int'(PT_PPB)) begin
        dp_addr[p] = dp_addr[p] & PPB_MASK;
      end
    end
  end

  // requester-side response mux
  always_comb begin
    for (int r = 0; r < NREQ; r++) begin
      rq_ready[r] = rt[r].fault;
      rq_err[r]   = rt[r].fault;
      rq_rdata[r] = '0;
      for (int p = 0; p < NPORT; p++) begin
        if (port_gnt[p][r] && dp_ready[p]) begin
          rq_ready[r] = 1'b1;
          rq_err[r]   = rq_err[r] | dp_err[p];
          rq_rdata[r] = rq_rdata[r] | dp_rdata[p];
        end
      end
    end
  end
endmodule

// File: rtl/route_chk.sv
module route_chk
  import xbar_route_pkg::*;
#(
  parameter int PPB_AW = 20
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NPORT-1:0][NREQ-1:0]   port_gnt,
  input logic [NPORT-1:0]             dp_valid,
  input logic [NPORT-1:0]             dp_ready,
  input logic [NPORT-1:0][ADDR_W-1:0] dp_addr,
  input logic [NREQ-1:0]              rq_valid,
  input logic [NREQ-1:0][ADDR_W-1:0]  rq_addr,
  input logic [NREQ-1:0]              rq_ready,
  input logic [NREQ-1:0]              rq_err
);
  // R1
  icode_no_debug_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_gnt[PT_ICODE][RQ_DEBUG]);

  // R4
  ppb_addr_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_valid[PT_PPB] |-> ((dp_addr[PT_PPB] >> PPB_AW) == '0));

  for (genvar p = 0; p < NPORT; p++) begin : g_pc
    // R8
    port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dp_valid[p] && !dp_ready[p] |=> (port_gnt[p] == $past(port_gnt[p])) && $stable(dp_addr[p]));
    // R7
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(port_gnt[p]));
  end

  for (genvar r = 0; r < NREQ; r++) begin : g_rc
    // R6
    internal_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rq_valid[r] && (rq_addr[r][31:18] == 14'h3800) |-> rq_ready[r] && rq_err[r]);
  end
endmodule

bind bus_route_top route_chk #(.PPB_AW(PPB_AW)) i_route_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .port_gnt (port_gnt),
  .dp_valid (dp_valid),
  .dp_ready (dp_ready),
  .dp_addr  (dp_addr),
  .rq_valid (rq_valid),
  .rq_addr  (rq_addr),
  .rq_ready (rq_ready),
  .rq_err   (rq_err)
);

// File: tb/test_bus_route_top.sv
`timescale 1ns/1ps
module test_bus_route_top;
  import xbar_route_pkg::*;
  localparam int DW = 32;
  localparam int PAW = 20;

  logic clk, rst_n;
  logic [NREQ-1:0]              rq_valid, rq_write, rq_priv, rq_ready, rq_err;
  logic [NREQ-1:0][31:0]        rq_addr;
  logic [NREQ-1:0][1:0]         rq_size;
  logic [NREQ-1:0][DW-1:0]      rq_wdata, rq_rdata;
  logic [NPORT-1:0]             dp_valid, dp_write, dp_ready, dp_err;
  logic [NPORT-1:0][31:0]       dp_addr;
  logic [NPORT-1:0][1:0]        dp_size;
  logic [NPORT-1:0][DW-1:0]     dp_wdata, dp_rdata;

  int checks = 0, fails = 0, cyc = 0;
  int wt [NPORT];
  logic [7:0] cnt [NPORT];
  bit [32:0] q0[$], q1[$], q2[$];

  bus_route_top #(.DATA_W(DW), .PPB_AW(PAW)) i_bus_route_top (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] tag(int p);
    return 32'h1000_0000 * (p + 1);
  endfunction

  // port models
  for (genvar p = 0; p < NPORT; p++) begin : g_rsp
    assign dp_ready[p] = dp_valid[p] && (int'(cnt[p]) >= wt[p]);
    assign dp_rdata[p] = dp_addr[p] ^ tag(p);
    assign dp_err[p]   = (dp_addr[p][7:0] == 8'hEC);
    always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt[p] <= '0;
      else if (dp_valid[p] && dp_ready[p]) cnt[p] <= '0;
      else if (dp_valid[p]) cnt[p] <= cnt[p] + 8'd1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected route from the requirements: port index or -1 for refused
  function automatic int route_of(int r, logic [31:0] a, logic [1:0] sz, logic pv);
    if (a[31:29] == 3'b000) return (r == 1) ? 0 : 1;
    if (a[31:20] == 12'hE00) begin
      if (a[19:18] == 2'b00) return -1;
      if (r == 1 || !pv || sz != 2'd2) return -1;
      return 3;
    end
    return 2;
  endfunction

  task automatic issue(input int r, input logic [31:0] a, input logic [1:0] sz,
                       input logic pv, output int t_iss, output int t_done);
    int p;
    bit [32:0] e;
    p = route_of(r, a, sz, pv);
    if (p < 0) e = {1'b1, 32'h0};
    else e = {a[7:0] == 8'hEC, ((p == 3) ? (a & 32'h000F_FFFF) : a) ^ tag(p)};
    case (r)
      0: q0.push_back(e);
      1: q1.push_back(e);
      default: q2.push_back(e);
    endcase
    @(posedge clk); #1;
    rq_addr[r] = a; rq_size[r] = sz; rq_priv[r] = pv;
    rq_write[r] = 1'b0; rq_wdata[r] = a; rq_valid[r] = 1'b1;
    t_iss = cyc;
    forever begin
      @(negedge clk);
      if (rq_ready[r]) break;
    end
    t_done = cyc;
    @(posedge clk); #1;
    rq_valid[r] = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int r = 0; r < NREQ; r++) begin
        if (rq_valid[r] && rq_ready[r]) begin
          bit [32:0] e;
          bit emp;
          emp = (r == 0) ? (q0.size() == 0) : (r == 1) ? (q1.size() == 0) : (q2.size() == 0);
          if (emp) check(1'b0, "R9 unexpected response", 64'(r), 64'hFFFF);
          else begin
            case (r)
              0: e = q0.pop_front();
              1: e = q1.pop_front();
              default: e = q2.pop_front();
            endcase
            check({rq_err[r], rq_rdata[r]} == e, "R9 response data/err",
                  64'({rq_err[r], rq_rdata[r]}), 64'(e));
          end
        end
      end
    end
  end

  int ti0, td0, ti1, td1, ti2, td2;
  bit fin = 0;

  initial begin
    rst_n = 1'b0; rq_valid = '0; rq_addr = '0; rq_size = '0;
    rq_priv = '0; rq_write = '0; rq_wdata = '0;
    for (int p = 0; p < NPORT; p++) wt[p] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 during reset
    check(dp_valid == '0 && rq_ready == '0, "R11 reset idle", 64'({dp_valid, rq_ready}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dp_valid == '0 && rq_ready == '0, "R11 after release", 64'({dp_valid, rq_ready}), 0);

    // R1 fetch to code region -> port 0
    issue(1, 32'h0000_1234, 2'd2, 1'b1, ti0, td0);
    check(td0 == ti0, "R1 fetch zero-wait", 64'(td0 - ti0), 0);
    // R2 data and debug to code region -> port 1 (debug not on port 0)
    issue(0, 32'h1FFF_FF00, 2'd0, 1'b0, ti0, td0);
    issue(2, 32'h0000_0040, 2'd2, 1'b1, ti0, td0);
    // R3 system ranges from all requesters
    issue(0, 32'h2000_0000, 2'd2, 1'b0, ti0, td0);
    issue(1, 32'hDFFF_FFFC, 2'd2, 1'b1, ti0, td0);
    issue(2, 32'hE010_0000, 2'd1, 1'b1, ti0, td0);
    // R4 peripheral window, truncated address
    issue(0, 32'hE004_0010, 2'd2, 1'b1, ti0, td0);
    issue(2, 32'hE00F_FFFC, 2'd2, 1'b1, ti0, td0);
    // R5 refused peripheral accesses
    issue(0, 32'hE005_0000, 2'd2, 1'b0, ti0, td0);
    check(td0 == ti0, "R5 unpriv immediate", 64'(td0 - ti0), 0);
    issue(0, 32'hE005_0000, 2'd1, 1'b1, ti0, td0);
    check(td0 == ti0, "R5 size immediate", 64'(td0 - ti0), 0);
    issue(1, 32'hE005_0000, 2'd2, 1'b1, ti0, td0);
    // R6 internal window
    issue(2, 32'hE003_FFFC, 2'd2, 1'b1, ti0, td0);
    check(td0 == ti0, "R6 internal immediate", 64'(td0 - ti0), 0);
    // R9 port error passthrough
    issue(0, 32'h3000_00EC, 2'd2, 1'b0, ti0, td0);

    // R7 on port 1 with waits: data before debug
    wt[1] = 2;
    fork
      issue(0, 32'h0000_0100, 2'd2, 1'b0, ti0, td0);
      issue(2, 32'h0000_0200, 2'd2, 1'b1, ti2, td2);
    join
    check(td0 < td2, "R7 dcode data before debug", 64'(td0), 64'(td2));
    check(td2 - td0 >= 3, "R10 debug stalled", 64'(td2 - td0), 3);

    // R7 all three on system port: data, fetch, debug
    wt[2] = 1;
    fork
      issue(0, 32'h4000_0000, 2'd2, 1'b0, ti0, td0);
      issue(1, 32'h4000_0004, 2'd2, 1'b1, ti1, td1);
      issue(2, 32'h4000_0008, 2'd2, 1'b1, ti2, td2);
    join
    check(td0 < td1 && td1 < td2, "R7 sys order", 64'({td0[15:0], td1[15:0], td2[15:0]}), 0);

    // R8 lock: debug owns system port, higher priority arrives later
    wt[2] = 3;
    fork
      issue(2, 32'h5000_0000, 2'd2, 1'b1, ti2, td2);
      begin @(posedge clk); issue(0, 32'h5000_0010, 2'd2, 1'b0, ti0, td0); end
      begin @(posedge clk); issue(1, 32'h5000_0020, 2'd2, 1'b1, ti1, td1); end
    join
    check(td2 - ti2 == 3, "R8 owner finishes undisturbed", 64'(td2 - ti2), 3);
    check(td2 < td0 && td0 < td1, "R8 later requests wait", 64'({td2[15:0], td0[15:0], td1[15:0]}), 0);

    // R10 requesters on distinct ports do not stall each other
    wt[1] = 0; wt[2] = 0;
    fork
      issue(0, 32'h6000_0000, 2'd2, 1'b0, ti0, td0);
      issue(1, 32'h0000_0800, 2'd2, 1'b1, ti1, td1);
    join
    check(td0 == ti0 && td1 == ti1, "R10 parallel ports no stall", 64'({td0 - ti0, td1 - ti1}), 0);

    repeat (2) @(negedge clk);
    check(q0.size() + q1.size() + q2.size() == 0, "R9 all responses seen",
          64'(q0.size() + q1.size() + q2.size()), 0);
    fin = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule